// File: doc/BRIEF.md
# Way-Partitioned Cache Allocation Controller

This block decides where a set-associative last-level cache may place a new line. It keeps one way bitmask for each of four service classes and a fifth bitmask for fills started by I/O agents. Each logical processor is bound to one class. Every request is looked up against that class's mask, or against the I/O mask when the request is I/O-initiated. The surrounding cache supplies the per-way hit vector from its tag compare. The block answers one cycle later with the hit flag, the hitting way and, on a miss, the way to replace.

The masks limit only which ways may be replaced on a miss. A hit in any way is always reported, whatever the requester's mask says. Mask updates are checked before they are stored. A mask must have at least two set bits, and those bits must form one unbroken run. An update that fails either check is dropped and flagged. Each set keeps its own round-robin victim pointer. Because every stored mask is a single run, the next victim is found from the lowest and highest allowed way, with no full circular search.

Top module: `llc_way_alloc`

## Requirements
- R1: The block stores five way masks, selected by `mask_idx`: values 0 to 3 address the four class masks and value 4 addresses the I/O mask. A write with `mask_idx` from 5 to 7 changes no mask and raises no error.
- R2: A mask write with fewer than two bits set is rejected. The previous mask stays in force, and `mask_err` is high in the cycle after the write.
- R3: A mask write whose set bits are not one contiguous run is rejected in the same way as in R2. `mask_err` is low after every accepted write.
- R4: A bind write stores the 2-bit class `bind_cls` for processor `bind_lp`. Every later non-I/O request from that processor uses that class's mask.
- R5: When `req_hits` is nonzero, the response reports `rsp_hit`=1 and `rsp_hit_way` set to the lowest set bit of `req_hits`, even when that way lies outside the requester's mask. On a hit, `rsp_victim` is 0 and the set's pointer does not change.
- R6: On a miss, `rsp_victim` is the first way in the requester's mask found by stepping upward from the set's last victim, wrapping from way NUM_WAYS-1 to way 0. The victim is always inside the mask, and only misses move the set's pointer.
- R7: A request with `req_io`=1 ignores the processor binding and picks its victim only from the I/O mask.
- R8: After reset, all five masks allow every way and every processor is bound to class 0. The first miss in any set picks way 0, and `rsp_valid` and `mask_err` are 0.
- R9: Each request with `req_valid`=1 produces a registered response with `rsp_valid`=1 exactly one cycle later. Without a request, `rsp_valid` is 0 in the next cycle.
- R10: A mask or bind write in the same cycle as a request does not affect that request. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Mask write strobe |
| mask_idx | input | 3 | Mask select: 0-3 class, 4 I/O |
| mask_data | input | NUM_WAYS | New way mask |
| mask_err | output | 1 | Previous cycle's mask write was rejected |
| bind_we | input | 1 | Processor-to-class bind strobe |
| bind_lp | input | $clog2(NUM_LP) | Processor being bound |
| bind_cls | input | 2 | Class assigned to that processor |
| req_valid | input | 1 | Lookup request |
| req_io | input | 1 | Request is an I/O-initiated fill |
| req_lp | input | $clog2(NUM_LP) | Requesting processor |
| req_set | input | $clog2(NUM_SETS) | Set index |
| req_hits | input | NUM_WAYS | Per-way hit vector from the tag compare |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | $clog2(NUM_WAYS) | Lowest hitting way |
| rsp_victim | output | $clog2(NUM_WAYS) | Way to replace on a miss |

## Verification
Several properties are checked on every clock cycle:
- On each miss, the chosen victim must lie inside the selected mask.
- On each hit, the reported way must actually be hitting.
- A hit must leave the set's pointer unchanged.
- A rejected write must leave its target mask unchanged.
- Every stored mask must remain at least two ways wide and contiguous.

Other behaviours only the bench scenarios can show: the exact round-robin order within a class, the wrap-around after the highest allowed way, the independence of pointers across sets, and the effect of re-binding a processor. The same goes for the rule that an update arriving together with a request is applied only from the next request. A model in the bench tracks these through thousands of mixed random requests and mask writes.

// File: rtl/llc_way_alloc.sv
module llc_way_alloc #(
  parameter int NUM_WAYS = 20,
  parameter int NUM_LP   = 8,
  parameter int NUM_SETS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mask_we,
  input  logic [2:0]                  mask_idx,
  input  logic [NUM_WAYS-1:0]         mask_data,
  output logic                        mask_err,
  input  logic                        bind_we,
  input  logic [$clog2(NUM_LP)-1:0]   bind_lp,
  input  logic [1:0]                  bind_cls,
  input  logic                        req_valid,
  input  logic                        req_io,
  input  logic [$clog2(NUM_LP)-1:0]   req_lp,
  input  logic [$clog2(NUM_SETS)-1:0] req_set,
  input  logic [NUM_WAYS-1:0]         req_hits,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic [$clog2(NUM_WAYS)-1:0] rsp_hit_way,
  output logic [$clog2(NUM_WAYS)-1:0] rsp_victim
);
  localparam int WAY_W   = $clog2(NUM_WAYS);
  localparam int NUM_MSK = 5;
  localparam logic [2:0] IO_IDX = 3'd4;

  logic [NUM_WAYS-1:0] mask_q [NUM_MSK];
  logic [1:0]          cls_q  [NUM_LP];
  logic [WAY_W-1:0]    ptr_q  [NUM_SETS];

  function automatic logic legal_mask(input logic [NUM_WAYS-1:0] m);
    logic [NUM_WAYS-1:0] low;
    low = m & (~m + 1'b1);
    return ($countones(m) >= 2) && (((m + low) & m) == '0);
  endfunction

  logic                wr_ok, wr_bad, any_hit;
  logic [2:0]          sel_idx;
  logic [NUM_WAYS-1:0] sel_mask;
  logic [WAY_W-1:0]    lo, hi, hit_way, cur_ptr, victim_next;

  assign wr_ok    = mask_we && (mask_idx <= IO_IDX) && legal_mask(mask_data);
  assign wr_bad   = mask_we && (mask_idx <= IO_IDX) && !legal_mask(mask_data);
  assign sel_idx  = req_io ? IO_IDX : {1'b0, cls_q[req_lp]};
  assign sel_mask = mask_q[sel_idx];
  assign any_hit  = |req_hits;
  assign cur_ptr  = ptr_q[req_set];

  always_comb begin
    lo = '0;
    hi = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (sel_mask[w]) lo = WAY_W'(w);
    for (int w = 0; w < NUM_WAYS; w++)
      if (sel_mask[w]) hi = WAY_W'(w);
  end

  always_comb begin
    hit_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (req_hits[w]) hit_way = WAY_W'(w);
  end

  assign victim_next = (cur_ptr >= lo && cur_ptr < hi) ? cur_ptr + 1'b1 : lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_MSK; k++) mask_q[k] <= '1;
      for (int p = 0; p < NUM_LP; p++) cls_q[p] <= '0;
      for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= WAY_W'(NUM_WAYS - 1);
      mask_err    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_hit_way <= '0;
      rsp_victim  <= '0;
    end else begin
      mask_err  <= wr_bad;
      rsp_valid <= req_valid;
      if (wr_ok) mask_q[mask_idx] <= mask_data;
      if (bind_we) cls_q[bind_lp] <= bind_cls;
      if (req_valid) begin
        rsp_hit     <= any_hit;
        rsp_hit_way <= any_hit ? hit_way : '0;
        rsp_victim  <= any_hit ? '0 : victim_next;
        if (!any_hit) ptr_q[req_set] <= victim_next;
      end
    end
  end

  assert_victim_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit) |-> sel_mask[victim_next]);

  assert_hit_way_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_hit) |-> req_hits[hit_way]);

  assert_hit_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_hit) |=> ptr_q[$past(req_set)] == $past(cur_ptr));

  assert_response_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  for (genvar k = 0; k < NUM_MSK; k++) begin : g_mask_chk
    assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bad && mask_idx == 3'(k)) |=> $stable(mask_q[k]));
    assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      legal_mask(mask_q[k]));
  end
endmodule

// File: tb/llc_way_alloc_tb.sv
`timescale 1ns/1ps
module llc_way_alloc_tb;
  localparam int NW = 20, NL = 8, NS = 16;
  logic clk = 0, rst_n = 0;
  logic mask_we = 0, bind_we = 0, req_valid = 0, req_io = 0;
  logic [2:0] mask_idx = 0;
  logic [NW-1:0] mask_data = 0, req_hits = 0;
  logic [2:0] bind_lp = 0, req_lp = 0;
  logic [1:0] bind_cls = 0;
  logic [3:0] req_set = 0;
  logic mask_err, rsp_valid, rsp_hit;
  logic [4:0] rsp_hit_way, rsp_victim;
  int checks = 0, errors = 0;
  logic [NW-1:0] m_mask [5];
  logic [1:0] m_cls [NL];
  int m_ptr [NS];

  always #10 clk = ~clk;

  llc_way_alloc #(.NUM_WAYS(NW), .NUM_LP(NL), .NUM_SETS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_idx(mask_idx), .mask_data(mask_data),
    .mask_err(mask_err), .bind_we(bind_we), .bind_lp(bind_lp), .bind_cls(bind_cls),
    .req_valid(req_valid), .req_io(req_io), .req_lp(req_lp), .req_set(req_set),
    .req_hits(req_hits), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_hit_way(rsp_hit_way), .rsp_victim(rsp_victim));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ok_mask(input logic [NW-1:0] m);
    int ones = 0, runs = 0;
    for (int w = 0; w < NW; w++) begin
      if (m[w]) ones++;
      if (m[w] && (w == 0 || !m[w-1])) runs++;
    end
    return ones >= 2 && runs == 1;
  endfunction

  task automatic drive(input bit mwe, input int midx, input logic [NW-1:0] mdat,
                       input bit bwe, input int blp, input int bcls,
                       input bit rv, input bit rio, input int rlp, input int rset,
                       input logic [NW-1:0] rh, input string tag);
    logic [NW-1:0] sm;
    int e_hw = 0, e_v = 0;
    bit e_hit, e_err;
    e_hit = |rh;
    for (int w = NW - 1; w >= 0; w--) if (rh[w]) e_hw = w;
    sm = rio ? m_mask[4] : m_mask[m_cls[rlp]];
    if (!e_hit)
      for (int i = NW; i >= 1; i--)
        if (sm[(m_ptr[rset] + i) % NW]) e_v = (m_ptr[rset] + i) % NW;
    e_err = mwe && midx <= 4 && !ok_mask(mdat);
    mask_we = mwe; mask_idx = 3'(midx); mask_data = mdat;
    bind_we = bwe; bind_lp = 3'(blp); bind_cls = 2'(bcls);
    req_valid = rv; req_io = rio; req_lp = 3'(rlp); req_set = 4'(rset); req_hits = rh;
    @(posedge clk); @(negedge clk);
    mask_we = 0; bind_we = 0; req_valid = 0;
    chk({"R9 rsp_valid ", tag}, rsp_valid, rv);
    if (mwe) chk({"R2 R3 mask_err ", tag}, mask_err, e_err);
    if (rv) begin
      chk({"R5 hit ", tag}, rsp_hit, e_hit);
      chk({"R5 hit_way ", tag}, rsp_hit_way, e_hw);
      chk({"R6 victim ", tag}, rsp_victim, e_v);
      if (!e_hit) m_ptr[rset] = e_v;
    end
    if (mwe && midx <= 4 && !e_err) m_mask[midx] = mdat;
    if (bwe) m_cls[blp] = 2'(bcls);
  endtask

  task automatic req(input bit io, input int lp, input int s, input logic [NW-1:0] h, input string tag);
    drive(0, 0, '0, 0, 0, 0, 1, io, lp, s, h, tag);
  endtask

  task automatic wmask(input int idx, input logic [NW-1:0] d, input string tag);
    drive(1, idx, d, 0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) m_mask[k] = '1;
    for (int p = 0; p < NL; p++) m_cls[p] = 0;
    for (int s = 0; s < NS; s++) m_ptr[s] = NW - 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R8 rsp_valid after reset", rsp_valid, 0);
    chk("R8 mask_err after reset", mask_err, 0);
    req(0, 5, 3, '0, "R8 first miss way0");
    req(0, 5, 3, '0, "R6 rr");
    req(0, 5, 7, '0, "R6 other set");
    wmask(1, 20'h000F0, "R1 class1 ways4-7");
    drive(0, 0, '0, 1, 2, 1, 0, 0, 0, 0, '0, "R4 bind");
    for (int i = 0; i < 6; i++) req(0, 2, 9, '0, "R4 R6 class1 wrap");
    req(0, 2, 9, 20'h00001, "R5 hit outside mask");
    req(0, 2, 9, 20'h80100, "R5 lowest hit");
    req(0, 2, 9, '0, "R5 ptr unchanged");
    wmask(1, 20'h00010, "R2 one bit");
    wmask(1, 20'h00000, "R2 zero");
    wmask(1, 20'h00C30, "R3 split");
    req(0, 2, 9, '0, "R2 R3 mask kept");
    drive(1, 6, 20'h00003, 0, 0, 0, 0, 0, 0, 0, '0, "R1 idx6 ignored");
    req(0, 2, 9, '0, "R1 after idx6");
    wmask(4, 20'hC0000, "R7 io mask");
    for (int i = 0; i < 3; i++) req(1, 2, 4, '0, "R7 io fill");
    drive(1, 1, 20'h00003, 0, 0, 0, 1, 0, 2, 9, '0, "R10 same cycle write");
    req(0, 2, 9, '0, "R10 next uses new");
    drive(0, 0, '0, 1, 2, 3, 1, 0, 2, 9, '0, "R10 same cycle bind");
    req(0, 2, 9, '0, "R4 rebound class3");
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      int lo = $urandom_range(0, NW - 1);
      int len = $urandom_range(1, NW);
      logic [NW-1:0] m = '0, h = '0;
      for (int w = lo; w < NW && w < lo + len; w++) m[w] = 1'b1;
      if (r == 0) m = NW'($urandom);
      if ($urandom_range(0, 2) == 0) h[$urandom_range(0, NW - 1)] = 1'b1;
      drive(r < 2, $urandom_range(0, 5), m, r == 2, $urandom_range(0, NL - 1), $urandom_range(0, 3),
            r != 3, $urandom_range(0, 4) == 0, $urandom_range(0, NL - 1), $urandom_range(0, NS - 1),
            h, "R6 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule